// File: doc/BRIEF.md
# APB Zero-Fill Word Memory

This block is an APB completer that holds a small array of 32-bit words. A requester writes a word with an ordinary two-cycle APB write and reads it back with a two-cycle APB read. Each word has its own valid flag. A word that has never been written, or that was written before the last reset, reads back as zero. The block always completes in two cycles. It has no wait states and no error response.

A three-state machine follows the bus. `ST_IDLE` means no access is pending. A setup cycle (select high, enable low) moves the machine to `ST_WR_ACCESS` when the write flag is high, or to `ST_RD_ACCESS` when it is low. The next cycle is the enable cycle. At its closing edge the machine returns to `ST_IDLE`, or it takes the new branch directly if that edge sees another setup cycle. A write is committed only at the closing edge of an enable cycle whose state is `ST_WR_ACCESS`. Read data is registered at the setup edge, so it is on the read-data port throughout the enable cycle. In every other cycle the read-data port is zero.

Top module: `apb_zmem`

## Requirements
- R1: A setup cycle (`psel`=1, `penable`=0) starts an access. It moves the state machine to `ST_WR_ACCESS` if `pwrite`=1 and to `ST_RD_ACCESS` if `pwrite`=0. Any other cycle returns it to `ST_IDLE`.
- R2: A write stores the `pwdata` value present at the end of the enable cycle. A value on `pwdata` during the setup cycle is not stored.
- R3: During the enable cycle of a read, `prdata` equals the word most recently written at that address since reset.
- R4: A read of a word that has not been written since reset returns 0.
- R5: `prdata` is 0 in every cycle that does not directly follow a read setup cycle. This includes idle cycles and the enable cycle of a write.
- R6: An asynchronous active-low reset `rst_n` drives `prdata` to 0 at once and marks every word invalid. After reset, every word reads 0.
- R7: The word index is `paddr[7:2]` (64 words). `paddr[1:0]` have no effect on which word is accessed.
- R8: An address with any bit set above bit 7 is out of range. A write to it changes no word, and a read of it returns 0.
- R9: An enable cycle (`psel`=1, `penable`=1) that does not follow a setup cycle stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Completer select |
| penable | input | 1 | Enable (second) phase marker |
| pwrite | input | 1 | 1 = write, 0 = read, sampled in setup |
| paddr | input | 32 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, zero outside read enable cycles |

## Verification
The bench sweeps every word three times: first unwritten, then after a full write pass, then after a mid-read reset. A design that reset only `prdata` and not the valid flags would return stale words after the reset. A design that skipped the valid flags would return leftover array contents where zero is expected. Writes to addresses with low byte bits set, or with high bits set, catch an index taken from the wrong bits. They also catch an out-of-range write that wraps into word 0. The bench also checks `prdata` during write enable and idle cycles, changes `pwdata` between setup and enable, and issues a stray enable with no setup cycle before it. These catch a leaking read mux, data sampled in the wrong phase, and a write strobe that ignores the phase.

// File: rtl/apb_zmem_pkg.sv
package apb_zmem_pkg;

    // Phase of the bus transfer the completer expects in the next cycle.
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_RD_ACCESS = 2'd1,
        ST_WR_ACCESS = 2'd2
    } zm_state_e;

endpackage

// File: rtl/apb_zmem_fsm.sv
module apb_zmem_fsm
    import apb_zmem_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      psel,
    input  logic      penable,
    input  logic      pwrite,
    output zm_state_e st_q,
    output logic      wr_en,
    output logic      rd_load
);

    zm_state_e st_d;
    logic      setup_cyc;

    assign setup_cyc = psel && !penable;

    // Next-state selection.
    always_comb begin
        st_d = ST_IDLE;
        unique case (st_q)
            ST_IDLE: begin
                if (setup_cyc) st_d = pwrite ? ST_WR_ACCESS : ST_RD_ACCESS;
            end
            ST_RD_ACCESS: begin
                if (setup_cyc) st_d = pwrite ? ST_WR_ACCESS : ST_RD_ACCESS;
            end
            ST_WR_ACCESS: begin
                if (setup_cyc) st_d = pwrite ? ST_WR_ACCESS : ST_RD_ACCESS;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Control strobes.
    always_comb begin
        wr_en   = 1'b0;
        rd_load = 1'b0;
        unique case (st_q)
            ST_WR_ACCESS: wr_en = psel && penable;
            ST_RD_ACCESS: wr_en = 1'b0;
            ST_IDLE:      wr_en = 1'b0;
            default:      wr_en = 1'b0;
        endcase
        rd_load = setup_cyc && !pwrite;
    end

endmodule

// File: rtl/apb_zmem_store.sv
module apb_zmem_store #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_word
);

    localparam int IDX_W = $clog2(DEPTH);
    localparam int LSB   = 2;
    localparam int TOP_W = ADDR_W - IDX_W - LSB;

    logic [IDX_W-1:0]  idx;
    logic              in_range;
    logic [DEPTH-1:0]  vld_q;
    logic [DATA_W-1:0] mem_q [DEPTH];

    assign idx      = addr[IDX_W+LSB-1:LSB];
    assign in_range = (addr[ADDR_W-1:IDX_W+LSB] == {TOP_W{1'b0}});

    // One flop per word: reset invalidates the whole array in one step.
    for (genvar g = 0; g < DEPTH; g++) begin : g_vld
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                vld_q[g] <= 1'b0;
            else if (wr_en && in_range && (idx == IDX_W'(g)))
                vld_q[g] <= 1'b1;
        end
    end

    // Data array: no reset, contents gated by the valid flags.
    always_ff @(posedge clk) begin
        if (wr_en && in_range) mem_q[idx] <= wdata;
    end

    always_comb begin
        rd_word = '0;
        if (in_range && vld_q[idx]) rd_word = mem_q[idx];
    end

endmodule

// File: rtl/apb_zmem_rdout.sv
module apb_zmem_rdout #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_load,
    input  logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] prdata
);

    // Loaded at the read setup edge, cleared at every other edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       prdata <= '0;
        else if (rd_load) prdata <= rd_word;
        else              prdata <= '0;
    end

endmodule

// File: rtl/apb_zmem.sv
module apb_zmem
    import apb_zmem_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata
);

    zm_state_e         st_q;
    logic              wr_en;
    logic              rd_load;
    logic [DATA_W-1:0] rd_word;

    apb_zmem_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .st_q    (st_q),
        .wr_en   (wr_en),
        .rd_load (rd_load)
    );

    apb_zmem_store #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (paddr),
        .wr_en   (wr_en),
        .wdata   (pwdata),
        .rd_word (rd_word)
    );

    apb_zmem_rdout #(
        .DATA_W (DATA_W)
    ) u_rdout (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_load (rd_load),
        .rd_word (rd_word),
        .prdata  (prdata)
    );

endmodule

// File: rtl/apb_zmem_chk.sv
module apb_zmem_chk
    import apb_zmem_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [DATA_W-1:0] prdata,
    input zm_state_e         st_q,
    input logic              wr_en
);

    localparam int IDX_W = $clog2(DEPTH);
    localparam int TOP_W = ADDR_W - IDX_W - 2;

    logic out_of_range;
    assign out_of_range = (paddr[ADDR_W-1:IDX_W+2] != {TOP_W{1'b0}});

    AST_WR_SETUP_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !penable && pwrite) |=> (st_q == ST_WR_ACCESS)); // R1

    AST_WR_ONLY_IN_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (psel && penable)); // R2

    AST_ZERO_OUTSIDE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !(psel && !penable && !pwrite) |=> (prdata == '0)); // R5

    AST_RESET_ZERO: assert property (@(posedge clk)
        !rst_n |-> (prdata == '0)); // R6

    AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !penable && !pwrite && out_of_range) |=> (prdata == '0)); // R8

    AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |-> !wr_en); // R9

endmodule

bind apb_zmem apb_zmem_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .prdata  (prdata),
    .st_q    (st_q),
    .wr_en   (wr_en)
);

// File: tb/apb_zmem_tb.sv
module apb_zmem_tb;

    localparam int AW    = 32;
    localparam int DW    = 32;
    localparam int DEPTH = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          psel = 1'b0;
    logic          penable = 1'b0;
    logic          pwrite = 1'b0;
    logic [AW-1:0] paddr = '0;
    logic [DW-1:0] pwdata = '0;
    logic [DW-1:0] prdata;

    int n_vec = 0;
    int n_bad = 0;
    logic [DW-1:0] shadow [DEPTH];
    logic [DEPTH-1:0] written = '0;

    always #10 clk = ~clk;

    apb_zmem u_dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata)
    );

    function automatic logic [DW-1:0] pat(input int i, input logic [DW-1:0] salt);
        return (DW'(i) * 32'h9E37_79B1) ^ salt;
    endfunction

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: prdata=%h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Called at a negedge; returns at the negedge after the enable cycle.
    task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                             input logic [DW-1:0] d_setup);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d_setup;
        @(negedge clk);
        penable = 1'b1; pwdata = d;
        chk("R5 write enable cycle", prdata, '0);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        chk(req, prdata, exp);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    function automatic logic [DW-1:0] model(input int i);
        return written[i] ? shadow[i] : '0;
    endfunction

    initial begin
        #100000000;
        n_bad++;
        $display("FAIL watchdog: prdata=%h expected completion", prdata);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R6 reset state", prdata, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: every word unwritten reads zero.
        for (int i = 0; i < DEPTH; i++) bus_read(AW'(i * 4), '0, "R4 unwritten");

        // R2/R3: write all words, setup-phase data differs from enable data.
        for (int i = 0; i < DEPTH; i++) begin
            bus_write(AW'(i * 4), pat(i, 32'hA5A5_0F0F), ~pat(i, 32'hA5A5_0F0F));
            shadow[i] = pat(i, 32'hA5A5_0F0F);
            written[i] = 1'b1;
        end
        for (int i = 0; i < DEPTH; i++) bus_read(AW'(i * 4), model(i), "R3 readback");

        // R5: idle cycle reads zero.
        @(negedge clk);
        chk("R5 idle", prdata, '0);

        // R7: low address bits ignored on write and read.
        bus_write(32'h0000_0017, 32'h1234_5678, 32'h0);
        shadow[5] = 32'h1234_5678;
        bus_read(32'h0000_0014, model(5), "R7 alias write");
        bus_read(32'h0000_0016, model(5), "R7 alias read");

        // R8: out-of-range writes ignored, reads zero.
        bus_write(32'h0000_0100, 32'hDEAD_BEEF, 32'h0);
        bus_write(32'h8000_0008, 32'hCAFE_F00D, 32'h0);
        bus_read(32'h0000_0000, model(0), "R8 no wrap into word 0");
        bus_read(32'h0000_0008, model(2), "R8 no wrap into word 2");
        bus_read(32'h0000_0100, '0, "R8 oor read");
        bus_read(32'h8000_0008, '0, "R8 oor high read");

        // R9: stray enable without setup.
        psel = 1'b1; penable = 1'b1; pwrite = 1'b1; paddr = 32'h10; pwdata = 32'h5555_AAAA;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
        @(negedge clk);
        bus_read(32'h0000_0010, model(4), "R9 stray enable");

        // R1: back-to-back write then read with no idle between.
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = 32'h3C; pwdata = 32'h0;
        @(negedge clk);
        penable = 1'b1; pwdata = 32'h0BAD_CAFE;
        @(negedge clk);
        shadow[15] = 32'h0BAD_CAFE;
        bus_read(32'h0000_003C, model(15), "R1 back-to-back");

        // R6: asynchronous reset in the middle of a read enable cycle.
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = 32'h3C;
        @(negedge clk);
        penable = 1'b1;
        chk("R3 before reset", prdata, model(15));
        #3 rst_n = 1'b0;
        #1 chk("R6 async clear", prdata, '0);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        written = '0;
        @(negedge clk);
        for (int i = 0; i < DEPTH; i++) bus_read(AW'(i * 4), '0, "R6 invalidated");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule